// File: doc/BRIEF.md
# Systolic Matrix-Vector Product Array

This block computes the product y = A·x of a square N×N matrix A and an N-element vector x. It uses a linear chain of N multiply-accumulate cells. Cell j keeps element x[j] in a local register. The vector is loaded in one cycle through a wide preload port, and it stays in place for as many matrices as the caller wishes to stream through.

Matrix rows arrive in ordinary row order, one full row per cycle, with a valid strobe. An internal skew buffer delays column j of each row by j cycles. Element a[i][j] therefore reaches cell j on the same cycle as the running partial sum for row i. Seen from the cells, the matrix enters as a diagonal wavefront. Each cell adds its product to the partial sum arriving from its left neighbour and registers the result toward its right neighbour. The finished y[i] leaves the last cell. Rows fed on consecutive cycles produce results on consecutive cycles. Gaps in the row stream appear as the same gaps in the result stream.

Entries of A and x are DW-bit two's complement values. Results are ACCW = 2·DW + ceil(log2 N) bits wide, which is wide enough that no sum can overflow.

Top module: `sysmv_array`

## Requirements
- R1: While rst_n is low, y_valid is 0 and y_data is 0. Reset also clears every stored vector element to 0, so a row sent after reset with no preload yields 0.
- R2: For each accepted row i, y_data equals the sum over j of a[i][j]·x[j]. Entries are signed two's complement, with column j in row_data bits [j·DW +: DW] and x[j] in x_data bits [j·DW +: DW]. The result is signed and ACCW bits wide.
- R3: A row sampled with row_valid high at rising edge k produces its result with y_valid high in the cycle after rising edge k+N−1, and at no other time.
- R4: An isolated matrix sent as N consecutive valid rows gives exactly N consecutive cycles of y_valid. At most N rows are ever in flight.
- R5: row_data is ignored when row_valid is low. Such cycles leave no result and show up as y_valid low at the matching output cycle.
- R6: A rising edge with x_load high stores x_data into the cells. x_data is ignored when x_load is low. The stored vector is used unchanged by every later row until the next load, provided the load happens while no rows are in flight.
- R7: Matrices streamed back to back, with no idle cycle between them, give correct results with no idle cycle between them.
- R8: While y_valid is low, y_data keeps the last result (or 0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_load | input | 1 | Store x_data into the cells on this edge |
| x_data | input | N*DW | Vector to preload, element j in bits [j*DW +: DW] |
| row_valid | input | 1 | row_data holds a matrix row this cycle |
| row_data | input | N*DW | One matrix row, column j in bits [j*DW +: DW] |
| y_valid | output | 1 | y_data holds a finished result this cycle |
| y_data | output | ACCW | Signed dot product of one row with the stored vector |

## Verification
The hardest case to reach is a valid row entering while the skew buffer still holds older, different rows in its deeper columns, with bubbles scattered at random positions between them. Only then would a misaligned skew stage or a badly gated accumulator mix elements of two rows. The bench reaches this case by streaming many random matrices, first back to back and then with row_valid dropped at random. During the bubbles it drives garbage on row_data and x_data. It predicts the exact output cycle for each row and requires y_valid to be low, with y_data held, in every other cycle.

// File: rtl/mv_pkg.sv
package mv_pkg;

  // Result width that cannot overflow for n signed dw-bit products summed.
  function automatic int acc_width(input int dw, input int n);
    return 2 * dw + $clog2(n);
  endfunction

endpackage

// File: rtl/mv_skew.sv
// Delays column j of each incoming row by j cycles so the row reaches
// the cells as a diagonal wavefront.
module mv_skew #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*DW-1:0] row_data,
  output logic [N*DW-1:0] skew_data
);

  for (genvar j = 0; j < N; j++) begin : g_col
    if (j == 0) begin : g_direct
      assign skew_data[DW-1:0] = row_data[DW-1:0];
    end else begin : g_delay
      logic [DW-1:0] dly_q [j];
      logic [DW-1:0] dly_d [j];

      always_comb begin
        dly_d[0] = row_data[j*DW +: DW];
        for (int k = 1; k < j; k++) dly_d[k] = dly_q[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < j; k++) dly_q[k] <= '0;
        end else begin
          for (int k = 0; k < j; k++) dly_q[k] <= dly_d[k];
        end
      end

      assign skew_data[j*DW +: DW] = dly_q[j-1];
    end
  end

endmodule

// File: rtl/mv_cell.sv
// One systolic cell: holds a stationary vector element and adds its
// product with the arriving matrix element to the passing partial sum.
module mv_cell #(
  parameter int DW   = 8,
  parameter int ACCW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_load,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   a_in,
  input  logic            vld_in,
  input  logic [ACCW-1:0] psum_in,
  output logic            vld_out,
  output logic [ACCW-1:0] psum_out
);

  logic [DW-1:0]          x_q;
  logic [ACCW-1:0]        psum_q;
  logic                   vld_q;
  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] prod_ext;
  logic [ACCW-1:0]        psum_d;

  always_comb begin
    prod     = $signed(a_in) * $signed(x_q);
    prod_ext = ACCW'(prod);
    psum_d   = psum_in + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      psum_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_in;
      if (vld_in) psum_q <= psum_d;
      if (x_load) x_q    <= x_in;
    end
  end

  assign vld_out  = vld_q;
  assign psum_out = psum_q;

  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> $stable(psum_out)); // R5

  AST_X_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    x_load |=> (x_q == $past(x_in))); // R6

  AST_X_STATIONARY: assert property (@(posedge clk) disable iff (!rst_n)
    !x_load |=> $stable(x_q)); // R6

endmodule

// File: rtl/sysmv_array.sv
module sysmv_array
  import mv_pkg::*;
#(
  parameter  int N    = 4,
  parameter  int DW   = 8,
  localparam int ACCW = acc_width(DW, N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_load,
  input  logic [N*DW-1:0] x_data,
  input  logic            row_valid,
  input  logic [N*DW-1:0] row_data,
  output logic            y_valid,
  output logic [ACCW-1:0] y_data
);

  localparam int CNTW = $clog2(N + 1) + 1;

  logic [N*DW-1:0] skew_data;
  logic [ACCW-1:0] psum [N+1];
  logic            vld  [N+1];

  mv_skew #(.N(N), .DW(DW)) skew_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_data  (row_data),
    .skew_data (skew_data)
  );

  assign psum[0] = '0;
  assign vld[0]  = row_valid;

  for (genvar j = 0; j < N; j++) begin : g_cell
    mv_cell #(.DW(DW), .ACCW(ACCW)) cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .x_load   (x_load),
      .x_in     (x_data[j*DW +: DW]),
      .a_in     (skew_data[j*DW +: DW]),
      .vld_in   (vld[j]),
      .psum_in  (psum[j]),
      .vld_out  (vld[j+1]),
      .psum_out (psum[j+1])
    );
  end

  assign y_valid = vld[N];
  assign y_data  = psum[N];

  // Occupancy tracker used only by the checks below.
  logic [CNTW-1:0] inflight_q;
  logic [CNTW-1:0] inflight_d;

  always_comb begin
    inflight_d = inflight_q + CNTW'(row_valid) - CNTW'(y_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_d;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!y_valid && (y_data == '0))); // R1

  AST_NO_ORPHAN: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> (inflight_q != '0)); // R3

  AST_INFLIGHT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CNTW'(N)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !y_valid |-> $stable(y_data)); // R8

endmodule

// File: tb/sysmv_array_tb_top.sv
module sysmv_array_tb_top;

  localparam int  N          = 4;
  localparam int  DW         = 8;
  localparam int  ACCW       = 2 * DW + $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            x_load = 1'b0;
  logic [N*DW-1:0] x_data = '0;
  logic            row_valid = 1'b0;
  logic [N*DW-1:0] row_data = '0;
  logic            y_valid;
  logic [ACCW-1:0] y_data;

  sysmv_array #(.N(N), .DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_load    (x_load),
    .x_data    (x_data),
    .row_valid (row_valid),
    .row_data  (row_data),
    .y_valid   (y_valid),
    .y_data    (y_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  int xm [N];
  int am [N][N];
  logic [ACCW-1:0] exp_val [$];
  int              exp_cyc [$];
  logic [ACCW-1:0] last_y = '0;
  bit mon_en = 1'b0;
  int vcount = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Output monitor: every cycle is either a predicted result or a bubble.
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        chk(y_valid == 1'b1, "R3 result timing", y_valid, 1);
        chk(y_data == exp_val[0], "R2 dot product",
            $signed(y_data), $signed(exp_val[0]));
        last_y = y_data;
        vcount++;
        void'(exp_val.pop_front());
        void'(exp_cyc.pop_front());
      end else begin
        chk(y_valid == 1'b0, "R5 bubble/idle valid", y_valid, 0);
        chk(y_data == last_y, "R8 output hold", $signed(y_data), $signed(last_y));
      end
    end
  end

  function automatic int rnd_elem();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  task automatic drive_row(input bit v, input int r);
    longint s;
    @(negedge clk);
    x_load    = 1'b0;
    x_data    = {N{8'($urandom)}};
    row_valid = v;
    s = 0;
    for (int j = 0; j < N; j++) begin
      row_data[j*DW +: DW] = v ? DW'(am[r][j]) : DW'($urandom);
      s += longint'(am[r][j]) * longint'(xm[j]);
    end
    if (v) begin
      exp_val.push_back(ACCW'(s));
      exp_cyc.push_back(cyc + N);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive_row(1'b0, 0);
  endtask

  task automatic send_matrix(input int bubble_pct);
    for (int r = 0; r < N; r++) begin
      while (int'($urandom_range(0, 99)) < bubble_pct) drive_row(1'b0, 0);
      drive_row(1'b1, r);
    end
  endtask

  task automatic rand_matrix();
    for (int r = 0; r < N; r++)
      for (int j = 0; j < N; j++) am[r][j] = rnd_elem();
  endtask

  task automatic load_x(input int mode);
    @(negedge clk);
    row_valid = 1'b0;
    x_load    = 1'b1;
    for (int j = 0; j < N; j++) begin
      xm[j] = (mode == 0) ? rnd_elem() : mode;
      x_data[j*DW +: DW] = DW'(xm[j]);
    end
  endtask

  initial begin
    for (int j = 0; j < N; j++) xm[j] = 0;
    for (int r = 0; r < N; r++) for (int j = 0; j < N; j++) am[r][j] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(y_valid == 1'b0, "R1 reset valid", y_valid, 0);
    chk(y_data == '0, "R1 reset data", y_data, 0);
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;

    // R1: vector cleared by reset, so any row gives zero
    rand_matrix();
    send_matrix(0);
    idle(N + 2);

    // R4: isolated matrix, exactly N valid cycles
    load_x(0);
    rand_matrix();
    vcount = 0;
    send_matrix(0);
    idle(N + 2);
    chk(vcount == N, "R4 valid run length", vcount, N);

    // R7: back-to-back matrices, vector held throughout (R6)
    for (int m = 0; m < 30; m++) begin
      rand_matrix();
      send_matrix(0);
    end
    idle(N + 2);

    // R5: random bubbles with garbage on the data inputs
    load_x(0);
    for (int m = 0; m < 30; m++) begin
      rand_matrix();
      send_matrix(40);
    end
    idle(N + 2);

    // R2: extreme operand values
    load_x(-128);
    for (int r = 0; r < N; r++) for (int j = 0; j < N; j++) am[r][j] = (r % 2 == 0) ? -128 : 127;
    send_matrix(0);
    idle(N + 2);
    load_x(127);
    for (int r = 0; r < N; r++) for (int j = 0; j < N; j++) am[r][j] = (j == r) ? 127 : -128;
    send_matrix(0);
    idle(N + 2);

    // R1: reset in the middle of a stream
    load_x(0);
    rand_matrix();
    send_matrix(0);
    drive_row(1'b1, 1);
    @(negedge clk);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    row_valid = 1'b0;
    #1;
    chk(y_valid == 1'b0, "R1 mid-stream reset valid", y_valid, 0);
    chk(y_data == '0, "R1 mid-stream reset data", y_data, 0);
    exp_val.delete();
    exp_cyc.delete();
    for (int j = 0; j < N; j++) xm[j] = 0;
    last_y = '0;
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    rand_matrix();
    send_matrix(0);
    idle(N + 2);

    chk(exp_cyc.size() == 0, "R3 all results seen", exp_cyc.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule